// File: doc/BRIEF.md
# Software Tablewalk Assist Register File

This block sits beside a software-managed TLB and shortens the miss handler. When a translation miss happens, the faulting effective address is latched. Handler code then reads two address registers. Each read returns a finished table-entry address, built from a stored base and slices of the latched page number. The handler does not have to do the shifting and masking itself.

The handler first loads the segment attributes and then writes the real page number. That single write commits a new TLB entry. The entry combines the written value with the latched page number, the address-space tag and the segment attributes. The entry goes out as a one-cycle write request. The request carries the slot index taken from the control register. After each commit the index steps forward on its own. If the reserve option is enabled, the step skips the lowest slots.

Software accesses the registers through a one-word-per-cycle port, so writes are serialized. A register select picks one of five registers: control (0), page number (1), first-level base (2), segment (3) and real page (4). Reads are combinational.

Top module: `twalk_assist`

## Requirements
- R1: After reset, the control register reads 0x04000000, the slot index is 0 and no entry request is raised.
- R2: The page-number register (select 1) keeps only bits [31:12] (page), bit 9 (entry valid) and bits [3:0] (space tag). All other bits read as zero.
- R3: A miss loads miss address bits [31:12] into the page field and leaves the valid flag and the space tag untouched. If a software write to select 1 happens in the same cycle, the software write wins.
- R4: Reading select 2 returns the stored base bits [31:12], with page bits [19:10] placed in bits [11:2] and zeros in bits [1:0].
- R5: Reading select 3 returns the stored second-level base bits [31:12], with page bits [9:0] placed in bits [11:2] and zeros in bits [1:0].
- R6: A write to select 4 raises the entry request for exactly the following cycle. The request carries the current slot index, the written word, the page, the valid flag, the space tag and segment bits [8:0]. Back-to-back writes give back-to-back requests.
- R7: After each commit, the slot index advances by one and wraps from 31 to 0.
- R8: When control bit 27 is set, any step that would land below slot 4 lands on slot 4 instead.
- R9: A write to select 0 stores control bits [31:24] and loads the slot index from bits [12:8]. Control reads return only those fields.
- R10: A commit uses the register contents from before the commit cycle, even when a miss is captured in that same cycle.
- R11: Selects 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr | input | 1 | Register write strobe |
| sr_sel | input | 3 | Register select |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data for the selected register |
| miss_valid | input | 1 | Translation miss capture strobe |
| miss_ea | input | 32 | Faulting effective address |
| tlbw_valid | output | 1 | One-cycle TLB entry write request |
| tlbw_index | output | 5 | Slot to load |
| tlbw_rpn | output | 32 | Real page word as written |
| tlbw_page | output | 20 | Effective page number of the entry |
| tlbw_asid | output | 4 | Address-space tag of the entry |
| tlbw_evalid | output | 1 | Entry valid flag |
| tlbw_attr | output | 9 | Segment attributes (protection group, guarded, size, write-through, segment valid) |

## Verification
The hardest cases to reach are the same-cycle collisions: a miss arriving in the same cycle as a page-number write, or in the same cycle as a commit. Neither happens in normal handler flow. The stimulus drives the miss strobe and the register write in one cycle on purpose, and the scoreboard predicts the older page. The reserve floor is reached from two start points, slot 31 and slot 1, so that both the wrap case and the plain-increment case land on slot 4.

// File: rtl/twa_pkg.sv
package twa_pkg;
  localparam int XLEN       = 32;
  localparam int PAGE_LSB   = 12;
  localparam int PAGE_W     = XLEN - PAGE_LSB;
  localparam int ASID_W     = 4;
  localparam int ATTR_W     = 9;
  localparam int EVALID_BIT = 9;
  localparam int IDX_LSB    = 8;
  localparam int CTRL_HI_W  = 8;
  localparam int RESV_BIT   = 27;
  localparam logic [XLEN-1:0] CTRL_RST = 32'h0400_0000;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_EPN   = 3'd1,
    SEL_TBASE = 3'd2,
    SEL_SEG   = 3'd3,
    SEL_RPN   = 3'd4
  } sel_e;

  // first-level entry address: base | (upper ten page bits << 2)
  function automatic logic [XLEN-1:0] l1_entry(input logic [PAGE_W-1:0] base,
                                               input logic [PAGE_W-1:0] page);
    return {base, page[PAGE_W-1 -: 10], 2'b00};
  endfunction

  // second-level entry address: base | (lower ten page bits << 2)
  function automatic logic [XLEN-1:0] l2_entry(input logic [PAGE_W-1:0] base,
                                               input logic [PAGE_W-1:0] page);
    return {base, {PAGE_LSB{1'b0}}} | {{PAGE_W{1'b0}}, page[9:0], 2'b00};
  endfunction
endpackage

// File: rtl/twa_idx_ctr.sv
module twa_idx_ctr #(
  parameter int IDX_W = 5,
  parameter int RSV_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  input  logic             reserve,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] FLOOR = IDX_W'(RSV_N);

  function automatic logic [IDX_W-1:0] idx_after(input logic [IDX_W-1:0] cur,
                                                 input logic resv);
    logic [IDX_W-1:0] n;
    n = cur + 1'b1;
    if (resv && n < FLOOR) n = FLOOR;
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     idx <= '0;
    else if (load)  idx <= load_val;
    else if (step)  idx <= idx_after(idx, reserve);
  end
endmodule

// File: rtl/twa_rd_mux.sv
module twa_rd_mux
  import twa_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [2:0]           sel,
  input  logic [CTRL_HI_W-1:0] ctrl_hi,
  input  logic [IDX_W-1:0]     idx,
  input  logic [PAGE_W-1:0]    page,
  input  logic                 evalid,
  input  logic [ASID_W-1:0]    asid,
  input  logic [PAGE_W-1:0]    l1_base,
  input  logic [PAGE_W-1:0]    l2_base,
  input  logic [XLEN-1:0]      rpn,
  output logic [XLEN-1:0]      rdata
);
  logic [XLEN-1:0] ctrl_word, epn_word;

  always_comb begin
    ctrl_word = {ctrl_hi, {(XLEN-CTRL_HI_W){1'b0}}} | (XLEN'(idx) << IDX_LSB);
    epn_word  = {page, {PAGE_LSB{1'b0}}} | (XLEN'(evalid) << EVALID_BIT) | XLEN'(asid);
    case (sel)
      SEL_CTRL:  rdata = ctrl_word;
      SEL_EPN:   rdata = epn_word;
      SEL_TBASE: rdata = l1_entry(l1_base, page);
      SEL_SEG:   rdata = l2_entry(l2_base, page);
      SEL_RPN:   rdata = rpn;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/twalk_assist.sv
module twalk_assist
  import twa_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int RSV_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wr,
  input  logic [2:0]        sr_sel,
  input  logic [31:0]       sr_wdata,
  output logic [31:0]       sr_rdata,
  input  logic              miss_valid,
  input  logic [31:0]       miss_ea,
  output logic              tlbw_valid,
  output logic [IDX_W-1:0]  tlbw_index,
  output logic [31:0]       tlbw_rpn,
  output logic [19:0]       tlbw_page,
  output logic [3:0]        tlbw_asid,
  output logic              tlbw_evalid,
  output logic [8:0]        tlbw_attr
);
  // decoded write events, named for the checker
  logic wr_ctrl, wr_epn, wr_tb, wr_seg, commit;
  assign wr_ctrl = sr_wr && (sr_sel == SEL_CTRL);
  assign wr_epn  = sr_wr && (sr_sel == SEL_EPN);
  assign wr_tb   = sr_wr && (sr_sel == SEL_TBASE);
  assign wr_seg  = sr_wr && (sr_sel == SEL_SEG);
  assign commit  = sr_wr && (sr_sel == SEL_RPN);

  logic [CTRL_HI_W-1:0] ctrl_hi;
  logic [PAGE_W-1:0]    page, l1_base, l2_base;
  logic                 evalid;
  logic [ASID_W-1:0]    asid;
  logic [ATTR_W-1:0]    seg_attr;
  logic [XLEN-1:0]      rpn_q;
  logic [IDX_W-1:0]     idx_cur;
  logic                 resv;

  assign resv = ctrl_hi[RESV_BIT-(XLEN-CTRL_HI_W)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_hi  <= CTRL_RST[XLEN-1 -: CTRL_HI_W];
      page     <= '0;
      evalid   <= 1'b0;
      asid     <= '0;
      l1_base  <= '0;
      l2_base  <= '0;
      seg_attr <= '0;
      rpn_q    <= '0;
    end else begin
      if (wr_ctrl) ctrl_hi <= sr_wdata[XLEN-1 -: CTRL_HI_W];
      if (wr_epn) begin
        page   <= sr_wdata[XLEN-1:PAGE_LSB];
        evalid <= sr_wdata[EVALID_BIT];
        asid   <= sr_wdata[ASID_W-1:0];
      end else if (miss_valid) begin
        page   <= miss_ea[XLEN-1:PAGE_LSB];
      end
      if (wr_tb) l1_base <= sr_wdata[XLEN-1:PAGE_LSB];
      if (wr_seg) begin
        l2_base  <= sr_wdata[XLEN-1:PAGE_LSB];
        seg_attr <= sr_wdata[ATTR_W-1:0];
      end
      if (commit) rpn_q <= sr_wdata;
    end
  end

  // entry request, registered: one cycle after the commit write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tlbw_valid  <= 1'b0;
      tlbw_index  <= '0;
      tlbw_rpn    <= '0;
      tlbw_page   <= '0;
      tlbw_asid   <= '0;
      tlbw_evalid <= 1'b0;
      tlbw_attr   <= '0;
    end else begin
      tlbw_valid <= commit;
      if (commit) begin
        tlbw_index  <= idx_cur;
        tlbw_rpn    <= sr_wdata;
        tlbw_page   <= page;
        tlbw_asid   <= asid;
        tlbw_evalid <= evalid;
        tlbw_attr   <= seg_attr;
      end
    end
  end

  twa_idx_ctr #(.IDX_W(IDX_W), .RSV_N(RSV_N)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_ctrl),
    .load_val (sr_wdata[IDX_LSB +: IDX_W]),
    .step     (commit),
    .reserve  (resv),
    .idx      (idx_cur)
  );

  twa_rd_mux #(.IDX_W(IDX_W)) u_rd (
    .sel     (sr_sel),
    .ctrl_hi (ctrl_hi),
    .idx     (idx_cur),
    .page    (page),
    .evalid  (evalid),
    .asid    (asid),
    .l1_base (l1_base),
    .l2_base (l2_base),
    .rpn     (rpn_q),
    .rdata   (sr_rdata)
  );
endmodule

// File: rtl/twa_chk.sv
module twa_chk #(
  parameter int IDX_W = 5,
  parameter int RSV_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit,
  input logic             wr_ctrl,
  input logic             miss_valid,
  input logic             wr_epn,
  input logic [31:0]      miss_ea,
  input logic [19:0]      page,
  input logic [2:0]       sr_sel,
  input logic [31:0]      sr_rdata,
  input logic             tlbw_valid,
  input logic [IDX_W-1:0] tlbw_index,
  input logic [IDX_W-1:0] idx_cur,
  input logic             resv
);
  p_reset_state_r1: assert property (@(posedge clk) $rose(rst_n) |-> (idx_cur == '0) && !tlbw_valid);

  p_pulse_rise_r6: assert property (@(posedge clk) disable iff (!rst_n) commit |=> tlbw_valid);
  p_pulse_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n) !commit |=> !tlbw_valid);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !resv && !wr_ctrl && (idx_cur == {IDX_W{1'b1}})) |=> (idx_cur == '0));

  p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && resv) |=> (idx_cur >= IDX_W'(RSV_N)));

  p_miss_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !wr_epn) |=> (page == $past(miss_ea[31:12])));

  p_l1_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_sel == 3'd2) |-> (sr_rdata[11:2] == page[19:10]) && (sr_rdata[1:0] == 2'b00));

  p_l2_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_sel == 3'd3) |-> (sr_rdata[11:2] == page[9:0]) && (sr_rdata[1:0] == 2'b00));

  p_commit_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (tlbw_index == $past(idx_cur)));
endmodule

bind twalk_assist twa_chk #(.IDX_W(IDX_W), .RSV_N(RSV_N)) u_twa_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .commit     (commit),
  .wr_ctrl    (wr_ctrl),
  .miss_valid (miss_valid),
  .wr_epn     (wr_epn),
  .miss_ea    (miss_ea),
  .page       (page),
  .sr_sel     (sr_sel),
  .sr_rdata   (sr_rdata),
  .tlbw_valid (tlbw_valid),
  .tlbw_index (tlbw_index),
  .idx_cur    (idx_cur),
  .resv       (resv)
);

// File: tb/test_twalk_assist.sv
module test_twalk_assist;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_wr = 1'b0;
  logic [2:0]  sr_sel = 3'd0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_ea = '0;
  logic        tlbw_valid;
  logic [4:0]  tlbw_index;
  logic [31:0] tlbw_rpn;
  logic [19:0] tlbw_page;
  logic [3:0]  tlbw_asid;
  logic        tlbw_evalid;
  logic [8:0]  tlbw_attr;

  always #10 clk = ~clk;

  twalk_assist i_twalk_assist (
    .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_sel(sr_sel), .sr_wdata(sr_wdata),
    .sr_rdata(sr_rdata), .miss_valid(miss_valid), .miss_ea(miss_ea),
    .tlbw_valid(tlbw_valid), .tlbw_index(tlbw_index), .tlbw_rpn(tlbw_rpn),
    .tlbw_page(tlbw_page), .tlbw_asid(tlbw_asid), .tlbw_evalid(tlbw_evalid),
    .tlbw_attr(tlbw_attr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // expected entry: {index, rpn, page, asid, valid, attr}
  logic [70:0] exp_q[$];

  // software model
  logic [31:0] m_ctrl, m_epn, m_tb, m_seg;
  logic [4:0]  m_idx;

  task automatic check(input string req, input logic [70:0] act, input logic [70:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] step_idx(input logic [4:0] i, input logic rsv);
    int n;
    n = (int'(i) + 1) % 32;
    if (rsv && n < 4) n = 4;
    return 5'(n);
  endfunction

  // keeps the allowed fields only
  function automatic logic [31:0] epn_keep(input logic [31:0] w);
    return w & 32'hFFFF_F20F;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    sr_wr = 1'b1; sr_sel = sel; sr_wdata = d;
    @(posedge clk); #1;
    sr_wr = 1'b0;
    case (sel)
      3'd0: begin m_ctrl = d & 32'hFF00_0000; m_idx = d[12:8]; end
      3'd1: m_epn = epn_keep(d);
      3'd2: m_tb = d;
      3'd3: m_seg = d;
      default: ;
    endcase
  endtask

  // driver: commit an entry and push the predicted request
  task automatic commit_entry(input logic [31:0] rpn);
    exp_q.push_back({m_idx, rpn, m_epn[31:12], m_epn[3:0], m_epn[9], m_seg[8:0]});
    m_idx = step_idx(m_idx, m_ctrl[27]);
    wr(3'd4, rpn);
  endtask

  task automatic rd(input string req, input logic [2:0] sel, input logic [31:0] exp);
    sr_sel = sel; #1;
    check(req, {39'd0, sr_rdata}, {39'd0, exp});
  endtask

  function automatic logic [31:0] l1_exp();
    return (m_tb & 32'hFFFF_F000) | ((m_epn >> 22) << 2);
  endfunction
  function automatic logic [31:0] l2_exp();
    return (m_seg & 32'hFFFF_F000) | (((m_epn >> 12) & 32'h3FF) << 2);
  endfunction

  // monitor: pop and compare on every request
  always @(negedge clk) begin
    if (rst_n && tlbw_valid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected request", 71'd1, 71'd0);
      end else begin
        check("R6/R7/R8/R10 entry",
              {tlbw_index, tlbw_rpn, tlbw_page, tlbw_asid, tlbw_evalid, tlbw_attr},
              exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_ctrl = 32'h0400_0000; m_epn = '0; m_tb = '0; m_seg = '0; m_idx = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd("R1 ctrl reset", 3'd0, 32'h0400_0000);
    check("R1 no request", {70'd0, tlbw_valid}, 71'd0);

    // R2 field masking
    wr(3'd1, 32'hFFFF_FFFF);
    rd("R2 epn mask", 3'd1, 32'hFFFF_F20F);
    wr(3'd1, 32'h1234_5205);
    rd("R2 epn value", 3'd1, 32'h1234_5205);

    // R4 / R5 computed addresses
    wr(3'd2, 32'hABCD_E123);
    rd("R4 l1 address", 3'd2, l1_exp());
    wr(3'd3, 32'h5550_01FD);
    rd("R5 l2 address", 3'd3, l2_exp());

    // R9 control load and read-back
    wr(3'd0, 32'h04FF_0300);
    rd("R9 ctrl readback", 3'd0, 32'h0400_0300);

    // R6 back-to-back commits from slot 3
    commit_entry(32'hAAAA_0001);
    commit_entry(32'hAAAA_0002);
    commit_entry(32'hAAAA_0003);
    rd("R6 rpn readback", 3'd4, 32'hAAAA_0003);
    rd("R7 index after three", 3'd0, 32'h0400_0600);

    // R7 wrap 31 -> 0
    wr(3'd0, 32'h0400_1F00);
    commit_entry(32'h0000_1111);
    commit_entry(32'h0000_2222);
    rd("R7 wrapped index", 3'd0, 32'h0400_0100);

    // R8 reserve floor, from 31 and from 1
    wr(3'd0, 32'h0C00_1F00);
    commit_entry(32'h0000_3333);
    commit_entry(32'h0000_4444);
    wr(3'd0, 32'h0C00_0100);
    commit_entry(32'h0000_5555);
    rd("R8 floor after 1", 3'd0, 32'h0C00_0400);
    commit_entry(32'h0000_6666);

    // R3 miss capture keeps valid and tag
    miss_valid = 1'b1; miss_ea = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    miss_valid = 1'b0;
    m_epn = (m_epn & 32'h0000_0FFF) | 32'hDEAD_B000;
    rd("R3 miss capture", 3'd1, m_epn);
    rd("R4 l1 after miss", 3'd2, l1_exp());
    rd("R5 l2 after miss", 3'd3, l2_exp());

    // R3 software write beats same-cycle miss
    miss_valid = 1'b1; miss_ea = 32'h7777_7000;
    wr(3'd1, 32'h0101_0003);
    miss_valid = 1'b0;
    rd("R3 write wins", 3'd1, 32'h0101_0003);

    // R10 commit with simultaneous miss uses old page
    miss_valid = 1'b1; miss_ea = 32'h3333_3000;
    commit_entry(32'hCAFE_0000);
    miss_valid = 1'b0;
    m_epn = (m_epn & 32'h0000_0FFF) | 32'h3333_3000;
    rd("R10 miss still taken", 3'd1, m_epn);

    // R11 unused selects
    rd("R11 read sel5", 3'd5, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd("R11 read sel6", 3'd6, 32'h0);
    rd("R11 ctrl untouched", 3'd0, m_ctrl | (32'(m_idx) << 8));
    rd("R11 epn untouched", 3'd1, m_epn);
    rd("R11 rpn untouched", 3'd4, 32'hCAFE_0000);

    repeat (3) @(posedge clk); #1;
    check("R6 all requests seen", 71'(exp_q.size()), 71'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule